// File: doc/BRIEF.md
# Loopback Serial Port Register Model

This block models the register file of a classic 16550-style serial port without any line-side hardware. Host software talks to it through eight byte-wide registers on a small strobe bus. Every byte written to the data register lands in a 16-entry circular receive queue, and reads of that same register hand the bytes back in order. Driver code written for a real port therefore sees its own traffic returned, along with believable line status, modem status and interrupt identification values.

Interrupts come from register accesses, not from levels. An access that meets one of the enabled conditions produces a trigger. The trigger reaches the single request output as a one-cycle pulse, but only while the interrupt is not masked. Each delivered pulse masks further ones automatically until the host unmasks through a dedicated input. A divisor latch, reached through the line-control access bit, holds a 16-bit value that is stored and read back but drives no baud logic.

Top module: `loopback_uart_regs`

## Requirements
- R1: After synchronous reset the line status reads 0x60, interrupt identification 0xC1, modem status 0xB3, and the interrupt enable, line control, modem control and scratch registers read 0x00. The queue is empty, its depth limit is 16 and the receive trigger level is 1.
- R2: A write to offset 0 with the divisor access bit (line control bit 7) clear enqueues the byte when the queue holds fewer bytes than its depth limit. A read of offset 0 dequeues the oldest byte. Bytes come back in first-in first-out order. A read of an empty queue returns 0x00. Read data appears on bus_rdata in the cycle after the read strobe.
- R3: A data write while the queue is at its depth limit discards the byte and sets the overrun flag. The flag stays set until the next successful enqueue clears it. The overflowing write raises a trigger if interrupt enable bit 2 is set.
- R4: Writing line control with bit 7 set enters divisor mode and zeroes the 16-bit divisor. In divisor mode, writes to offset 0 OR into the divisor's low byte and writes to offset 1 OR into its high byte, and reads of those offsets return the two bytes. The queue and the interrupt enable register are left untouched.
- R5: A write to offset 2 (queue control) with bit 1 or bit 2 set empties the queue. Bit 0 selects a depth limit of 16 when set and 1 when clear. The bits 7:6 trigger field is ignored, and the trigger level stays 1.
- R6: A read of offset 1 with divisor mode off returns only the low four bits of the interrupt enable register. The upper bits read as zero.
- R7: A read of offset 2 returns the OR of the codes of every active cause, or 0x01 when the OR is zero, with bits 7:6 always set. The cause codes are: 0x06 for overrun with enable bit 2; 0x04 for queue count at or above the trigger level with enable bit 0; 0x02 for an empty queue with enable bit 1; 0x00 for modem control bit 0 or 1 with enable bit 3.
- R8: Offset 5 (line status) sets bit 0 when the queue is non-empty and bit 1 while overrun is set. It sets bits 5 and 6 when the queue is empty.
- R9: Offset 6 (modem status) always sets bits 7, 5 and 1. It also sets bits 4 and 0 when modem control bit 5 is clear, or when that bit is set and the queue is below its depth limit.
- R10: A successful enqueue raises a trigger when enable bit 0 is set and the new count equals the trigger level exactly.
- R11: A trigger is raised by an interrupt enable write with bit 1 set while the queue is empty. One is also raised by a data read, with enable bit 1 set, that leaves the queue empty, including a read of an already empty queue.
- R12: With enable bit 3 set, a modem control write raises a trigger when the written value has bit 3, bit 1 or bit 0 set.
- R13: A trigger pulses irq for one cycle, in the cycle after the access, only while unmasked. Delivery sets the mask. irq_mask sets the mask, irq_unmask clears it, and unmask wins when both apply in one cycle.
- R14: Writes to offsets 5 and 6 are ignored. Offset 7 is a plain read/write byte. Line and modem control read back the last value written. A cycle with both strobes high performs only the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after bus_rd |
| irq_mask | input | 1 | Sets the interrupt mask |
| irq_unmask | input | 1 | Clears the interrupt mask |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench fills the queue to its limit and pushes one more byte. This shows the drop and the overrun flag, and that only the next accepted byte clears the flag; a design that wrapped its pointers would return the extra byte instead. It checks that the divisor latch ORs rather than overwrites, and that divisor-mode writes never reach the queue. It checks that a modem-only cause collapses to 0xC1, which a design using priority codes would report differently. On the interrupt side it confirms that a second trigger without an unmask is swallowed, that a read of an empty queue still fires, and that the trigger-level field of the queue control write has no effect on the trigger count.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    localparam int unsigned FIFO_DEPTH    = 16;
    localparam int unsigned REG_W         = 8;
    localparam int unsigned DIV_W         = 2 * REG_W;
    localparam int unsigned RX_TRIG_LEVEL = 1;

    typedef logic [REG_W-1:0] reg_byte_t;

    typedef enum logic [2:0] {
        OFF_DATA      = 3'd0,
        OFF_IENABLE   = 3'd1,
        OFF_IDENT     = 3'd2,
        OFF_LINECTL   = 3'd3,
        OFF_MODEMCTL  = 3'd4,
        OFF_LINESTAT  = 3'd5,
        OFF_MODEMSTAT = 3'd6,
        OFF_SCRATCH   = 3'd7
    } reg_off_e;

    // interrupt enable bit positions
    localparam int unsigned IE_RXDATA  = 0;
    localparam int unsigned IE_TXEMPTY = 1;
    localparam int unsigned IE_LINE    = 2;
    localparam int unsigned IE_MODEM   = 3;

    // line control / queue control / modem control bit positions
    localparam int unsigned LC_DIVACC   = 7;
    localparam int unsigned QC_ENABLE   = 0;
    localparam int unsigned QC_CLR_A    = 1;
    localparam int unsigned QC_CLR_B    = 2;
    localparam int unsigned MC_DTR      = 0;
    localparam int unsigned MC_RTS      = 1;
    localparam int unsigned MC_OUT2     = 3;
    localparam int unsigned MC_AUTOFLOW = 5;

    // identification codes
    localparam reg_byte_t ID_LINE    = 8'h06;
    localparam reg_byte_t ID_RXDATA  = 8'h04;
    localparam reg_byte_t ID_TXEMPTY = 8'h02;
    localparam reg_byte_t ID_MODEM   = 8'h00;
    localparam reg_byte_t ID_NONE    = 8'h01;
    localparam reg_byte_t ID_FIXED   = 8'hC0;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic txempty;
        logic modem;
    } cause_t;

    typedef struct packed {
        reg_byte_t        ienable;
        reg_byte_t        linectl;
        reg_byte_t        modemctl;
        reg_byte_t        scratch;
        logic [DIV_W-1:0] divisor;
        logic             divacc;
        logic             overrun;
        logic             qenable;
    } port_state_t;

    function automatic reg_byte_t ident_value(input cause_t c);
        reg_byte_t v;
        v = '0;
        if (c.line)    v = v | ID_LINE;
        if (c.rxdata)  v = v | ID_RXDATA;
        if (c.txempty) v = v | ID_TXEMPTY;
        if (c.modem)   v = v | ID_MODEM;
        if (v == '0)   v = ID_NONE;
        return v | ID_FIXED;
    endfunction

    function automatic reg_byte_t linestat_value(input logic nonempty, input logic ovr);
        reg_byte_t v;
        v    = '0;
        v[0] = nonempty;
        v[1] = ovr;
        v[5] = ~nonempty;
        v[6] = ~nonempty;
        return v;
    endfunction

    function automatic reg_byte_t modemstat_value(input logic autoflow, input logic has_room);
        reg_byte_t v;
        v    = '0;
        v[7] = 1'b1;
        v[5] = 1'b1;
        v[1] = 1'b1;
        if (!autoflow || has_room) begin
            v[4] = 1'b1;
            v[0] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/lbu_fifo.sv
module lbu_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head_byte,
    output logic [CNT_W-1:0] count
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (push) begin
            wr_ptr <= next_ptr(wr_ptr);
            count  <= count + CNT_W'(1);
        end else if (pop) begin
            rd_ptr <= next_ptr(rd_ptr);
            count  <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[wr_ptr] <= wdata;
        end
    end

    assign head_byte = mem[rd_ptr];

    AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)) else $error("queue count above depth"); // R2
    AST_FIFO_POP_DEC: assert property (@(posedge clk) disable iff (rst) (pop && !push && !clear && count != '0) |=> (count == $past(count) - CNT_W'(1))) else $error("pop did not decrement"); // R2
    AST_FIFO_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst) clear |=> (count == '0)) else $error("clear left data"); // R5

endmodule

// File: rtl/lbu_irq_gate.sv
module lbu_irq_gate (
    input  logic clk,
    input  logic rst,
    input  logic fire_req,
    input  logic mask_set,
    input  logic mask_clr,
    output logic irq
);

    logic mask_q;
    logic deliver;

    assign deliver = fire_req && !mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= deliver;
            if (mask_clr) begin
                mask_q <= 1'b0;
            end else if (deliver || mask_set) begin
                mask_q <= 1'b1;
            end
        end
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst) (fire_req && mask_q) |=> !irq) else $error("masked trigger delivered"); // R13
    AST_AUTO_MASK: assert property (@(posedge clk) disable iff (rst) (irq && !$past(mask_clr)) |-> mask_q) else $error("delivery left mask clear"); // R13
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) (irq && !$past(mask_clr)) |=> !irq) else $error("pulse longer than one cycle"); // R13

endmodule

// File: rtl/lbu_readsel.sv
module lbu_readsel
    import lbu_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  reg_off_e         off,
    input  port_state_t      st,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    input  reg_byte_t        head_byte,
    output reg_byte_t        rd_val
);

    logic   nonempty;
    cause_t causes;

    assign nonempty = (count != '0);

    always_comb begin
        causes.line    = st.ienable[IE_LINE] && st.overrun;
        causes.rxdata  = st.ienable[IE_RXDATA] && (count >= CNT_W'(RX_TRIG_LEVEL));
        causes.txempty = st.ienable[IE_TXEMPTY] && !nonempty;
        causes.modem   = st.ienable[IE_MODEM] && (st.modemctl[MC_RTS] || st.modemctl[MC_DTR]);
    end

    always_comb begin
        unique case (off)
            OFF_DATA:      rd_val = st.divacc ? st.divisor[REG_W-1:0]
                                              : (nonempty ? head_byte : '0);
            OFF_IENABLE:   rd_val = st.divacc ? st.divisor[DIV_W-1:REG_W]
                                              : {4'h0, st.ienable[3:0]};
            OFF_IDENT:     rd_val = ident_value(causes);
            OFF_LINECTL:   rd_val = st.linectl;
            OFF_MODEMCTL:  rd_val = st.modemctl;
            OFF_LINESTAT:  rd_val = linestat_value(nonempty, st.overrun);
            OFF_MODEMSTAT: rd_val = modemstat_value(st.modemctl[MC_AUTOFLOW], count < limit);
            OFF_SCRATCH:   rd_val = st.scratch;
            default:       rd_val = '0;
        endcase
    end

endmodule

// File: rtl/loopback_uart_regs.sv
module loopback_uart_regs
    import lbu_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_mask,
    input  logic       irq_unmask,
    output logic       irq
);

    localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

    reg_off_e         off;
    port_state_t      st;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;
    reg_byte_t        head_byte;
    reg_byte_t        rd_val;
    logic             rd_acc;
    logic             data_wr;
    logic             q_push;
    logic             q_drop;
    logic             q_pop;
    logic             q_clear;
    logic             empty;
    cause_t           trig;
    logic             trig_thr_ie;
    logic             trig_thr_rd;
    logic             fire_req;

    assign off     = reg_off_e'(bus_addr);
    assign rd_acc  = bus_rd && !bus_wr;
    assign empty   = (count == '0);
    assign limit   = st.qenable ? CNT_W'(DEPTH) : CNT_W'(1);

    // access decode
    assign data_wr = bus_wr && (off == OFF_DATA) && !st.divacc;
    assign q_push  = data_wr && (count < limit);
    assign q_drop  = data_wr && !(count < limit);
    assign q_pop   = rd_acc && (off == OFF_DATA) && !st.divacc && !empty;
    assign q_clear = bus_wr && (off == OFF_IDENT) && (bus_wdata[QC_CLR_A] || bus_wdata[QC_CLR_B]);

    // trigger events
    always_comb begin
        trig.rxdata  = q_push && st.ienable[IE_RXDATA]
                       && ((count + CNT_W'(1)) == CNT_W'(RX_TRIG_LEVEL));
        trig.line    = q_drop && st.ienable[IE_LINE];
        trig_thr_ie  = bus_wr && (off == OFF_IENABLE) && !st.divacc
                       && bus_wdata[IE_TXEMPTY] && empty;
        trig_thr_rd  = rd_acc && (off == OFF_DATA) && !st.divacc
                       && st.ienable[IE_TXEMPTY] && (count <= CNT_W'(1));
        trig.txempty = trig_thr_ie || trig_thr_rd;
        trig.modem   = bus_wr && (off == OFF_MODEMCTL) && st.ienable[IE_MODEM]
                       && (bus_wdata[MC_OUT2] || bus_wdata[MC_RTS] || bus_wdata[MC_DTR]);
        fire_req     = trig.rxdata || trig.line || trig.txempty || trig.modem;
    end

    // register state
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{ienable: '0, linectl: '0, modemctl: '0, scratch: '0,
                    divisor: '0, divacc: 1'b0, overrun: 1'b0, qenable: 1'b1};
        end else if (bus_wr) begin
            unique case (off)
                OFF_DATA: begin
                    if (st.divacc) begin
                        st.divisor[REG_W-1:0] <= st.divisor[REG_W-1:0] | bus_wdata;
                    end else if (q_push) begin
                        st.overrun <= 1'b0;
                    end else begin
                        st.overrun <= 1'b1;
                    end
                end
                OFF_IENABLE: begin
                    if (st.divacc) begin
                        st.divisor[DIV_W-1:REG_W] <= st.divisor[DIV_W-1:REG_W] | bus_wdata;
                    end else begin
                        st.ienable <= bus_wdata;
                    end
                end
                OFF_IDENT: begin
                    st.qenable <= bus_wdata[QC_ENABLE];
                end
                OFF_LINECTL: begin
                    st.linectl <= bus_wdata;
                    st.divacc  <= bus_wdata[LC_DIVACC];
                    if (bus_wdata[LC_DIVACC]) begin
                        st.divisor <= '0;
                    end
                end
                OFF_MODEMCTL: begin
                    st.modemctl <= bus_wdata;
                end
                OFF_SCRATCH: begin
                    st.scratch <= bus_wdata;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_acc) begin
            bus_rdata <= rd_val;
        end
    end

    lbu_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (REG_W),
        .CNT_W (CNT_W)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .pop       (q_pop),
        .clear     (q_clear),
        .wdata     (bus_wdata),
        .head_byte (head_byte),
        .count     (count)
    );

    lbu_readsel #(
        .CNT_W (CNT_W)
    ) u_readsel (
        .off       (off),
        .st        (st),
        .count     (count),
        .limit     (limit),
        .head_byte (head_byte),
        .rd_val    (rd_val)
    );

    lbu_irq_gate u_irq (
        .clk      (clk),
        .rst      (rst),
        .fire_req (fire_req),
        .mask_set (irq_mask),
        .mask_clr (irq_unmask),
        .irq      (irq)
    );

    AST_DIV_ZERO_ON_ENTRY: assert property (@(posedge clk) disable iff (rst) (bus_wr && off == OFF_LINECTL && bus_wdata[LC_DIVACC]) |=> (st.divisor == '0 && st.divacc)) else $error("divisor not cleared"); // R4
    AST_FULL_WRITE_DROPS: assert property (@(posedge clk) disable iff (rst) (data_wr && count == limit) |=> (count == $past(count) && st.overrun)) else $error("full write not dropped"); // R3
    AST_IER_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_acc && off == OFF_IENABLE && !st.divacc) |=> (bus_rdata[7:4] == 4'h0)) else $error("enable read upper bits"); // R6
    AST_IDENT_FIXED_BITS: assert property (@(posedge clk) disable iff (rst) (rd_acc && off == OFF_IDENT) |=> (bus_rdata[7:6] == 2'b11)) else $error("ident upper bits"); // R7
    AST_LSR_TX_EMPTY: assert property (@(posedge clk) disable iff (rst) (rd_acc && off == OFF_LINESTAT && empty) |=> (bus_rdata[6:5] == 2'b11 && !bus_rdata[0])) else $error("line status empty bits"); // R8
    AST_DIVMODE_QUEUE_HOLD: assert property (@(posedge clk) disable iff (rst) (bus_wr && off == OFF_DATA && st.divacc) |=> $stable(count)) else $error("divisor write reached queue"); // R4

endmodule

// File: tb/loopback_uart_regs_test.sv
module loopback_uart_regs_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_mask = 1'b0;
    logic       irq_unmask = 1'b0;
    logic       irq;
    logic       probe = 1'b0;

    always #5 clk = ~clk;

    loopback_uart_regs uut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_mask   (irq_mask),
        .irq_unmask (irq_unmask),
        .irq        (irq)
    );

    typedef struct {
        bit         is_read;
        logic [7:0] exp_d;
        bit         exp_irq;
        string      tag;
    } item_t;

    item_t sb[$];
    int    checks   = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    logic  mon_acc;
    item_t mon_it;

    // monitor: compares design results against scoreboard items
    always @(posedge clk) begin
        mon_acc = bus_wr | bus_rd | probe;
        #2;
        if (mon_acc && !rst) begin
            if (sb.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R2 scoreboard underflow actual=0 expected=1");
            end else begin
                mon_it = sb.pop_front();
                if (mon_it.is_read) begin
                    checks++;
                    if (bus_rdata !== mon_it.exp_d) begin
                        failures++;
                        $display("FAIL %s rdata actual=%02h expected=%02h", mon_it.tag, bus_rdata, mon_it.exp_d);
                    end
                end
                checks++;
                if (irq !== mon_it.exp_irq) begin
                    failures++;
                    $display("FAIL %s irq actual=%0b expected=%0b", mon_it.tag, irq, mon_it.exp_irq);
                end
            end
        end
    end

    task automatic push_item(input bit rd, input logic [7:0] d, input bit ei, input string tag);
        item_t it;
        it.is_read = rd;
        it.exp_d   = d;
        it.exp_irq = ei;
        it.tag     = tag;
        sb.push_back(it);
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d, input bit ei, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        push_item(1'b0, 8'h00, ei, tag);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, input logic [7:0] d, input bit ei, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        push_item(1'b1, d, ei, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_wrrd(input logic [2:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = a; bus_wdata = d;
        push_item(1'b0, 8'h00, 1'b0, tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic do_probe(input bit ei, input string tag);
        @(negedge clk);
        probe = 1'b1;
        push_item(1'b0, 8'h00, ei, tag);
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic pulse_unmask();
        @(negedge clk); irq_unmask = 1'b1;
        @(negedge clk); irq_unmask = 1'b0;
    endtask

    task automatic pulse_mask();
        @(negedge clk); irq_mask = 1'b1;
        @(negedge clk); irq_mask = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not complete actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_rd(3'd5, 8'h60, 1'b0, "R1 reset line status");
        do_rd(3'd2, 8'hC1, 1'b0, "R1 reset ident");
        do_rd(3'd1, 8'h00, 1'b0, "R1 reset enable");
        do_rd(3'd3, 8'h00, 1'b0, "R1 reset line ctl");
        do_rd(3'd4, 8'h00, 1'b0, "R1 reset modem ctl");
        do_rd(3'd7, 8'h00, 1'b0, "R1 reset scratch");
        do_rd(3'd6, 8'hB3, 1'b0, "R1 reset modem status");

        // R2 loopback order
        do_wr(3'd0, 8'h11, 1'b0, "R2 push");
        do_wr(3'd0, 8'h22, 1'b0, "R2 push");
        do_wr(3'd0, 8'h33, 1'b0, "R2 push");
        do_rd(3'd5, 8'h01, 1'b0, "R8 data ready");
        do_rd(3'd0, 8'h11, 1'b0, "R2 pop first");
        do_rd(3'd0, 8'h22, 1'b0, "R2 pop second");
        do_rd(3'd0, 8'h33, 1'b0, "R2 pop third");
        do_rd(3'd5, 8'h60, 1'b0, "R8 empty again");
        do_rd(3'd0, 8'h00, 1'b0, "R2 empty read zero");

        // R3 overflow, R9 autoflow
        for (int i = 0; i < 16; i++) do_wr(3'd0, 8'(8'h10 + i), 1'b0, "R3 fill");
        do_wr(3'd0, 8'hEE, 1'b0, "R3 overflow write");
        do_rd(3'd5, 8'h03, 1'b0, "R3 overrun and ready");
        do_rd(3'd6, 8'hB3, 1'b0, "R9 no autoflow");
        do_wr(3'd4, 8'h20, 1'b0, "R9 set autoflow");
        do_rd(3'd6, 8'hA2, 1'b0, "R9 autoflow full");
        for (int i = 0; i < 16; i++) do_rd(3'd0, 8'(8'h10 + i), 1'b0, "R3 drain order");
        do_rd(3'd5, 8'h62, 1'b0, "R3 overrun sticky");
        do_wr(3'd0, 8'h44, 1'b0, "R3 clearing push");
        do_rd(3'd5, 8'h01, 1'b0, "R3 overrun cleared");
        do_rd(3'd6, 8'hB3, 1'b0, "R9 autoflow room");
        do_rd(3'd0, 8'h44, 1'b0, "R3 dropped byte absent");
        do_wr(3'd4, 8'h00, 1'b0, "R14 modem ctl clear");

        // R4 divisor latch
        do_wr(3'd0, 8'h5A, 1'b0, "R4 queue byte");
        do_wr(3'd3, 8'h83, 1'b0, "R4 enter divisor mode");
        do_rd(3'd3, 8'h83, 1'b0, "R14 line ctl readback");
        do_wr(3'd0, 8'h0F, 1'b0, "R4 low write");
        do_wr(3'd0, 8'hF0, 1'b0, "R4 low or");
        do_rd(3'd0, 8'hFF, 1'b0, "R4 low accumulated");
        do_wr(3'd1, 8'h12, 1'b0, "R4 high write");
        do_rd(3'd1, 8'h12, 1'b0, "R4 high readback");
        do_wr(3'd3, 8'h83, 1'b0, "R4 reenter");
        do_rd(3'd0, 8'h00, 1'b0, "R4 low zeroed");
        do_rd(3'd1, 8'h00, 1'b0, "R4 high zeroed");
        do_wr(3'd3, 8'h03, 1'b0, "R4 leave divisor mode");
        do_rd(3'd1, 8'h00, 1'b0, "R4 enable untouched");
        do_rd(3'd5, 8'h01, 1'b0, "R4 queue untouched");
        do_rd(3'd0, 8'h5A, 1'b0, "R4 queue byte intact");

        // R6 enable read
        do_wr(3'd1, 8'hF5, 1'b0, "R6 enable write");
        do_rd(3'd1, 8'h05, 1'b0, "R6 low nibble only");
        do_rd(3'd2, 8'hC1, 1'b0, "R7 no active cause");
        do_wr(3'd1, 8'h00, 1'b0, "R6 enable clear");

        // R5 queue control, R10 trigger level
        do_wr(3'd2, 8'h00, 1'b0, "R5 depth one");
        do_wr(3'd0, 8'h61, 1'b0, "R5 first fits");
        do_wr(3'd0, 8'h62, 1'b0, "R5 second overflows");
        do_rd(3'd5, 8'h03, 1'b0, "R5 depth one overrun");
        do_rd(3'd0, 8'h61, 1'b0, "R5 kept byte");
        do_rd(3'd5, 8'h62, 1'b0, "R5 empty with overrun");
        do_wr(3'd2, 8'h01, 1'b0, "R5 depth sixteen");
        do_wr(3'd0, 8'h71, 1'b0, "R5 push");
        do_wr(3'd0, 8'h72, 1'b0, "R5 push");
        do_rd(3'd5, 8'h01, 1'b0, "R5 two bytes held");
        do_wr(3'd2, 8'h03, 1'b0, "R5 clear bit one");
        do_rd(3'd5, 8'h60, 1'b0, "R5 cleared by bit one");
        do_wr(3'd0, 8'h73, 1'b0, "R5 push");
        do_wr(3'd2, 8'h05, 1'b0, "R5 clear bit two");
        do_rd(3'd5, 8'h60, 1'b0, "R5 cleared by bit two");
        do_wr(3'd2, 8'hC1, 1'b0, "R5 trigger field fourteen");
        do_wr(3'd1, 8'h01, 1'b0, "R10 data enable");
        do_wr(3'd0, 8'h74, 1'b1, "R10 trigger at count one");
        pulse_unmask();
        do_rd(3'd2, 8'hC4, 1'b0, "R7 data cause");
        do_wr(3'd0, 8'h75, 1'b0, "R10 no trigger at count two");
        do_rd(3'd2, 8'hC4, 1'b0, "R7 data cause held");
        do_rd(3'd0, 8'h74, 1'b0, "R5 no clear on field");
        do_rd(3'd0, 8'h75, 1'b0, "R5 second byte");
        do_rd(3'd2, 8'hC1, 1'b0, "R7 data cause gone");
        do_wr(3'd1, 8'h00, 1'b0, "R6 enable clear");

        // R7 R11 R12 composition and triggers
        do_wr(3'd1, 8'h0F, 1'b1, "R11 enable write with empty queue");
        pulse_unmask();
        do_rd(3'd2, 8'hC2, 1'b0, "R7 tx empty cause");
        do_wr(3'd4, 8'h01, 1'b1, "R12 dtr trigger");
        pulse_unmask();
        do_rd(3'd2, 8'hC2, 1'b0, "R7 modem code adds nothing");
        do_wr(3'd1, 8'h08, 1'b0, "R11 no bit one no trigger");
        do_rd(3'd2, 8'hC1, 1'b0, "R7 modem only reads none");
        do_wr(3'd4, 8'h00, 1'b0, "R12 zero write no trigger");
        do_wr(3'd4, 8'h08, 1'b1, "R12 out2 trigger");
        pulse_unmask();
        do_wr(3'd1, 8'h04, 1'b0, "R3 line enable");
        for (int i = 0; i < 16; i++) do_wr(3'd0, 8'(8'h80 + i), 1'b0, "R3 fill no trigger");
        do_wr(3'd0, 8'hEE, 1'b1, "R3 overflow trigger");
        pulse_unmask();
        do_rd(3'd2, 8'hC6, 1'b0, "R7 line cause");
        do_wr(3'd1, 8'h07, 1'b0, "R11 bit one with data no trigger");
        do_rd(3'd2, 8'hC6, 1'b0, "R7 line or data");
        for (int i = 0; i < 15; i++) do_rd(3'd0, 8'(8'h80 + i), 1'b0, "R11 read not empty");
        do_rd(3'd0, 8'h8F, 1'b1, "R11 read leaves empty");
        pulse_unmask();
        do_rd(3'd0, 8'h00, 1'b1, "R11 read of empty queue");
        pulse_unmask();
        do_wr(3'd1, 8'h00, 1'b0, "R6 enable clear");
        do_wr(3'd0, 8'h01, 1'b0, "R3 clearing push");
        do_rd(3'd0, 8'h01, 1'b0, "R3 clearing byte");

        // R13 masking
        pulse_mask();
        do_wr(3'd1, 8'h02, 1'b0, "R13 masked trigger");
        do_rd(3'd1, 8'h02, 1'b0, "R6 enable readback");
        pulse_unmask();
        do_wr(3'd1, 8'h02, 1'b1, "R13 unmasked trigger");
        do_wr(3'd1, 8'h02, 1'b0, "R13 auto mask holds");
        pulse_unmask();
        do_wr(3'd1, 8'h08, 1'b0, "R13 enable modem");
        do_wr(3'd4, 8'h0B, 1'b1, "R13 double cause one pulse");
        do_probe(1'b0, "R13 pulse ended");
        do_wr(3'd4, 8'h00, 1'b0, "R12 zero write");
        pulse_unmask();
        do_wr(3'd1, 8'h00, 1'b0, "R6 enable clear");

        // R14 ignored writes, scratch, readback, both strobes
        do_wr(3'd5, 8'hFF, 1'b0, "R14 line status write");
        do_wr(3'd6, 8'h00, 1'b0, "R14 modem status write");
        do_rd(3'd5, 8'h60, 1'b0, "R14 line status unchanged");
        do_rd(3'd6, 8'hB3, 1'b0, "R14 modem status unchanged");
        do_wr(3'd7, 8'hA5, 1'b0, "R14 scratch write");
        do_rd(3'd7, 8'hA5, 1'b0, "R14 scratch read");
        do_wr(3'd3, 8'h1B, 1'b0, "R14 line ctl write");
        do_rd(3'd3, 8'h1B, 1'b0, "R14 line ctl read");
        do_wr(3'd4, 8'h37, 1'b0, "R14 modem ctl write");
        do_rd(3'd4, 8'h37, 1'b0, "R14 modem ctl read");
        do_rd(3'd6, 8'hB3, 1'b0, "R9 autoflow empty");
        do_wr(3'd0, 8'h99, 1'b0, "R14 push");
        do_wrrd(3'd0, 8'h9A, "R14 both strobes");
        do_rd(3'd0, 8'h99, 1'b0, "R14 no pop on both strobes");
        do_rd(3'd0, 8'h9A, 1'b0, "R14 write taken on both strobes");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R2 scoreboard leftover actual=%0d expected=0", sb.size());
        end
        finish_run();
    end

endmodule